// File: doc/BRIEF.md
# Key-Entry Port Input Debounce Filter

This block cleans up an 8-bit input port that is wired to mechanical keys. The eight pins form two groups of four: pins 3..0 and pins 7..4. Each group has its own 3-bit check-time code, and both codes live in one byte-wide control register. A nonzero code turns on the filter for its group. The check time is then a power-of-two number of clock cycles, from 2^BASE_LOG for code 1 up to 2^(BASE_LOG+6) for code 7. The default BASE_LOG of 8 gives 256 to 16384 cycles. Code 0 switches filtering off, and the pins of that group pass straight through.

Every raw pin first goes through a two-flop synchronizer. One free-running prescaler is shared by both groups. It gives each group a sampling tick at the group's check period. A pin takes a new level only when two consecutive ticks of its group both see that level. A pulse no longer than one period is therefore always dropped. A level that is held for two periods is always taken.

Each pin has a registered filtered output and a one-cycle change pulse, which an interrupt controller can use as its request. The HAS_HIGH parameter set to 0 builds a port with only four filtered pins. In that build the upper code cannot be set and pins 7..4 always pass straight through.

Top module: `keyport_filter`

## Requirements
- R1: After reset the control register reads 0x00, every filtered output is 0 and every change pulse is 0.
- R2: A write with ctl_we high stores the code for pins 3..0 from wdata[2:0] and the code for pins 7..4 from wdata[6:4]. From the next cycle, ctl_rdata returns the stored codes with bits 3 and 7 read as 0.
- R3: For a code c from 1 to 7, the check period is P = 2^(BASE_LOG+c-1) clock cycles.
- R4: A pulse on a filtered pin that lasts P cycles or fewer never changes the filtered output and never raises a change pulse.
- R5: A level change on a filtered pin that is held for good appears on pin_filt no earlier than P+3 and no later than 2P+3 rising clock edges after the raw pin changes.
- R6: With code 0 (filtering off), pin_filt follows pin_raw exactly 3 rising clock edges after the raw pin changes.
- R7: pin_irq is high for exactly one cycle, in the same cycle in which pin_filt of that pin changes. This holds for both rising and falling changes, and pin_irq is never high at any other time.
- R8: Each group is timed only by its own code: pins 7..4 behave according to wdata[6:4], whatever the code for pins 3..0 is, and the other way round.
- R9: With HAS_HIGH = 0, bits 6..4 of the control register always read 0, and pins 7..4 always behave as with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data (reserved bits 0) |
| pin_raw | input | 2*GRP_W | Raw asynchronous key inputs |
| pin_filt | output | 2*GRP_W | Debounced pin levels, registered |
| pin_irq | output | 2*GRP_W | One-cycle pulse on each filtered change |

## Verification
The assertions assume that reset is held for at least two cycles, so that the synchronizer and the prescaler start from known values. The tick-spacing property also assumes that the check-time codes do not change during the cycle being checked, and it is written to hold only while the codes stay the same. The bench changes a code only while every pin is idle, and it then waits more than two check periods before it moves any pin. It drives each raw pin only on the falling clock edge, one pin at a time, so every latency is measured from a known edge.

// File: rtl/kpf_pkg.sv
package kpf_pkg;
  localparam int NGRP      = 2;
  localparam int CODE_MAX  = 7;
  typedef logic [2:0] sel_t;
endpackage

// File: rtl/kpf_sync.sv
module kpf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/kpf_prescaler.sv
module kpf_prescaler
  import kpf_pkg::*;
#(
  parameter int BASE_LOG = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  sel_t            sel [NGRP],
  output logic [NGRP-1:0] tick
);
  localparam int CNT_W = BASE_LOG + CODE_MAX - 1;

  logic [CNT_W-1:0]    cnt;
  logic [CODE_MAX:0]   code_tick;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign code_tick[0] = 1'b0;
  for (genvar c = 1; c <= CODE_MAX; c++) begin : g_code
    // period 2^(BASE_LOG+c-1): low bits all ones
    assign code_tick[c] = &cnt[BASE_LOG+c-2:0];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign tick[g] = code_tick[sel[g]];

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (tick[g] && $stable(sel[g])) |=> !tick[g]);
  end
endmodule

// File: rtl/kpf_pin_filter.sv
module kpf_pin_filter (
  input  logic clk,
  input  logic rst,
  input  logic s_in,
  input  logic tick,
  input  logic bypass,
  output logic fout,
  output logic irq
);
  logic cand;
  logic acc;
  logic cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand <= 1'b0;
      acc  <= 1'b0;
    end else if (bypass) begin
      cand <= s_in;
      acc  <= s_in;
    end else if (tick) begin
      cand <= s_in;
      if (s_in == cand) acc <= s_in;
    end
  end

  assign cur = bypass ? s_in : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      fout <= 1'b0;
      irq  <= 1'b0;
    end else begin
      fout <= cur;
      irq  <= cur ^ fout;
    end
  end

  // R7
  irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (fout != $past(fout)) |-> irq);

  // R6
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (fout == $past(s_in)));

  // R4
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !tick) |=> $stable(acc));
endmodule

// File: rtl/keyport_filter.sv
module keyport_filter
  import kpf_pkg::*;
#(
  parameter int BASE_LOG = 8,
  parameter int GRP_W    = 4,
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_wdata,
  output logic [7:0]           ctl_rdata,
  input  logic [2*GRP_W-1:0]   pin_raw,
  output logic [2*GRP_W-1:0]   pin_filt,
  output logic [2*GRP_W-1:0]   pin_irq
);
  localparam int NPIN = NGRP * GRP_W;

  sel_t sel_lo;
  sel_t sel_hi;
  sel_t sel [NGRP];
  logic [NGRP-1:0] tick;
  logic [NPIN-1:0] s_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_lo <= '0;
      sel_hi <= '0;
    end else if (ctl_we) begin
      sel_lo <= ctl_wdata[2:0];
      sel_hi <= HAS_HIGH ? ctl_wdata[6:4] : 3'd0;
    end
  end

  assign sel[0]    = sel_lo;
  assign sel[1]    = sel_hi;
  assign ctl_rdata = {1'b0, sel_hi, 1'b0, sel_lo};

  kpf_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (s_pin)
  );

  kpf_prescaler #(.BASE_LOG(BASE_LOG)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .tick (tick)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int G = p / GRP_W;
    kpf_pin_filter u_pf (
      .clk    (clk),
      .rst    (rst),
      .s_in   (s_pin[p]),
      .tick   (tick[G]),
      .bypass (sel[G] == 3'd0),
      .fout   (pin_filt[p]),
      .irq    (pin_irq[p])
    );
  end

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_rdata[2:0] == $past(ctl_wdata[2:0])) && !ctl_rdata[3] && !ctl_rdata[7]);

  // R9
  no_high_chk: assert property (@(posedge clk) disable iff (rst)
    !HAS_HIGH |-> (ctl_rdata[6:4] == 3'd0));
endmodule

// File: tb/keyport_filter_test.sv
module keyport_filter_test;
  localparam int CLK_P    = 10;
  localparam int BASE_LOG = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we, we_lo;
  logic [7:0] wdata, wdata_lo, rdata, rdata_lo;
  logic [7:0] raw, raw_lo, filt, filt_lo, irq, irq_lo;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  keyport_filter #(.BASE_LOG(BASE_LOG), .GRP_W(4), .HAS_HIGH(1'b1)) uut (
    .clk(clk), .rst(rst), .ctl_we(we), .ctl_wdata(wdata), .ctl_rdata(rdata),
    .pin_raw(raw), .pin_filt(filt), .pin_irq(irq));

  keyport_filter #(.BASE_LOG(BASE_LOG), .GRP_W(4), .HAS_HIGH(1'b0)) uut_lo (
    .clk(clk), .rst(rst), .ctl_we(we_lo), .ctl_wdata(wdata_lo), .ctl_rdata(rdata_lo),
    .pin_raw(raw_lo), .pin_filt(filt_lo), .pin_irq(irq_lo));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one pin of uut to v and watch for win cycles.
  task automatic step(input int pin, input logic v, input int win,
                      output int lat, output int bad_irq, output int n_irq);
    logic prev;
    lat = -1; bad_irq = 0; n_irq = 0;
    prev = filt[pin];
    raw[pin] = v;
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      if (irq[pin]) n_irq++;
      if (irq[pin] != (filt[pin] != prev)) bad_irq++;
      if (lat < 0 && filt[pin] == v) lat = k;
      prev = filt[pin];
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat, bad, nirq, per, pin;
    logic changed;
    we = 0; wdata = 0; we_lo = 0; wdata_lo = 0; raw = 0; raw_lo = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(filt == 8'h00, "R1 filt", filt, 0);
    chk(irq == 8'h00, "R1 irq", irq, 0);

    // R2 register field layout, reserved bits
    wr(8'hFF);
    chk(rdata == 8'h77, "R2 rdata after 0xFF", rdata, 8'h77);
    wr(8'h5A);
    chk(rdata == 8'h52, "R2 rdata after 0x5A", rdata, 8'h52);
    wr(8'h00);
    chk(rdata == 8'h00, "R2 rdata after 0x00", rdata, 0);

    // R6 bypass latency on every pin, both directions
    for (int p = 0; p < 8; p++) begin
      step(p, 1'b1, 6, lat, bad, nirq);
      chk(lat == 3, "R6 bypass rise latency", lat, 3);
      chk(bad == 0 && nirq == 1, "R7 bypass rise irq", nirq, 1);
      step(p, 1'b0, 6, lat, bad, nirq);
      chk(lat == 3, "R6 bypass fall latency", lat, 3);
      chk(bad == 0 && nirq == 1, "R7 bypass fall irq", nirq, 1);
    end

    // Sweep both groups and every nonzero code
    for (int g = 0; g < 2; g++) begin
      for (int c = 1; c <= 7; c++) begin
        per = 1 << (BASE_LOG + c - 1);   // R3
        pin = 4 * g + (c % 4);
        wr(g == 0 ? 8'(c) : 8'(c << 4));
        idle(2 * per + 8);

        // R4 glitch of exactly P cycles rejected
        raw[pin] = 1'b1;
        idle(per);
        raw[pin] = 1'b0;
        changed = 1'b0; nirq = 0;
        for (int k = 0; k < 2 * per + 8; k++) begin
          @(negedge clk);
          if (filt[pin]) changed = 1'b1;
          if (irq[pin]) nirq++;
        end
        chk(!changed && nirq == 0, "R4 glitch rejected", nirq, 0);

        // R5 / R3 held level accepted within [P+3, 2P+3]
        step(pin, 1'b1, 2 * per + 8, lat, bad, nirq);
        chk(lat >= per + 3 && lat <= 2 * per + 3, "R5 rise latency", lat, per + 3);
        chk(bad == 0 && nirq == 1, "R7 filtered rise irq", nirq, 1);
        step(pin, 1'b0, 2 * per + 8, lat, bad, nirq);
        chk(lat >= per + 3 && lat <= 2 * per + 3, "R5 fall latency", lat, per + 3);
        chk(bad == 0 && nirq == 1, "R7 filtered fall irq", nirq, 1);

        // R8 other group stays in bypass
        step(4 * (1 - g), 1'b1, 5, lat, bad, nirq);
        chk(lat == 3, "R8 other group bypass", lat, 3);
        step(4 * (1 - g), 1'b0, 5, lat, bad, nirq);
        chk(lat == 3, "R8 other group bypass fall", lat, 3);
      end
    end

    // R9 low-only variant
    we_lo = 1'b1; wdata_lo = 8'hFF;
    @(negedge clk);
    we_lo = 1'b0;
    chk(rdata_lo == 8'h07, "R9 rdata low-only", rdata_lo, 8'h07);
    idle(40);
    raw_lo[6] = 1'b1;
    idle(3);
    chk(filt_lo[6] == 1'b1 && irq_lo[6] == 1'b1, "R9 high pin bypass", filt_lo[6], 1);
    raw_lo[1] = 1'b1;
    idle(3);
    chk(filt_lo[1] == 1'b0, "R9 low pin still filtered", filt_lo[1], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule